// File: doc/BRIEF.md
# Card Data FIFO Engine

This block is the data path of a memory-card host controller, seen from a 32-bit register bus. Software programs a byte length and then writes a control word with the enable bit set. The engine then moves data between a 16-word internal FIFO and a byte-wide card stream. In card-read mode it packs incoming card bytes into FIFO words, and the host pops them. In card-write mode the host pushes words, and the engine unpacks them to the card. Bytes are taken least significant first in both directions.

A remaining-byte counter tracks progress. A sticky block-end status bit is set once that counter is exhausted, and two interrupt lines each report the status masked by their own mask register. Each host pop stops further card-to-FIFO refill until software polls the status or word-count register. This gives a driver a stable FIFO to drain between polls.

Register offsets (byte addresses): length 0x28, control 0x2C, remaining bytes 0x30, status 0x34, status clear 0x38, mask A 0x3C, mask B 0x40, word count 0x48. The FIFO window spans 0x80 to 0xBC, and every word address in it reaches the same FIFO.

Top module: `card_fifo_engine`

## Requirements
- R1: After reset, the control, remaining-byte, status and both mask registers read 0, both interrupt lines are low, and no refill hold is pending.
- R2: A write to control (0x2C) keeps only bits [7:0]. When bit 0 (enable) is set in that write, the remaining-byte counter (read at 0x30) is loaded from the length register (0x28). Bit 1 set selects card-read mode and bit 1 clear selects card-write mode.
- R3: A read of 0x48 returns (remaining bytes + 3) >> 2.
- R4: In card-read mode, a byte is taken from the card in a cycle where both card_rx_valid_i and card_rx_ready_o are high, and each taken byte lowers the counter by one. Bytes fill FIFO words least significant byte first, and a final partial word has zero in its upper bytes. Ready stays low while the FIFO holds 16 words or the counter is zero.
- R5: In card-write mode, a host write to any FIFO window address while the counter is nonzero and the FIFO is not full pushes a word. The card side sends the FIFO words least significant byte first, one byte per cycle where card_tx_valid_i and card_tx_ready_i are both high, and stops when the counter reaches zero.
- R6: Status bit 0 (block end) is set in the cycle after the engine is enabled with a zero counter. It stays set until software writes a 1 to bit 0 at 0x38.
- R7: When the engine is enabled, the counter is zero and the FIFO is empty, the enable bit clears on the next clock.
- R8: A host read of the FIFO window that pops a word sets a hold. While the hold is set, card_rx_ready_o stays low and the counter does not change.
- R9: A read of 0x34 or 0x48 returns the current value and clears the hold.
- R10: A FIFO window read while the FIFO is empty returns 0 and sets no hold. A FIFO window write while the counter is zero is dropped.
- R11: Each bit of irq_o is a registered copy of the OR of (status AND its mask): bit 0 uses mask A and bit 1 uses mask B. Each bit follows a status or mask change one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 12 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| card_rx_valid_i | input | 1 | Card offers a byte |
| card_rx_data_i | input | 8 | Byte from the card |
| card_rx_ready_o | output | 1 | Engine accepts a card byte |
| card_tx_valid_o | output | 1 | Engine offers a byte to the card |
| card_tx_data_o | output | 8 | Byte to the card |
| card_tx_ready_i | input | 1 | Card accepts the byte |
| irq_o | output | 2 | Masked status interrupts |

## Verification
Some rules are checked by assertions on every cycle. These are:
- the FIFO never overflows or underflows;
- a pending hold keeps card_rx_ready_o low, and a poll releases it;
- each taken byte lowers the counter by exactly one;
- the engine goes idle once the counter and the FIFO are both exhausted;
- an empty-FIFO read returns zero without setting a hold.

Other behaviour is shown only by the bench scenarios. These cover the byte ordering inside packed and unpacked words, partial final words, stopping at sixteen words, the exact interrupt latency, and dropped writes once the count is exhausted.

// File: rtl/card_fifo_pkg.sv
package card_fifo_pkg;
  localparam int DATA_W = 32;
  localparam int BPW    = DATA_W / 8;
  localparam int LANE_W = $clog2(BPW);
  localparam int ADDR_W = 12;
  localparam int NIRQ   = 2;

  localparam logic [ADDR_W-1:0] OFS_LEN   = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 12'h02C;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_SCLR  = 12'h038;
  localparam logic [ADDR_W-1:0] OFS_MASK0 = 12'h03C;
  localparam logic [ADDR_W-1:0] OFS_FCNT  = 12'h048;
  localparam logic [ADDR_W-1:0] WIN_BASE  = 12'h080;
  localparam logic [ADDR_W-1:0] WIN_TOP   = 12'h0BC;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_RD  = 1;
  localparam int STAT_END = 0;
endpackage

// File: rtl/card_word_fifo.sv
module card_word_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_i) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + PTR_W'(1);
    if (pop_i)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + PTR_W'(1);
    if (push_i && !pop_i) cnt_d = cnt_q + CNT_W'(1);
    if (pop_i && !push_i) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= wr_d;
      if (pop_i)  rd_q <= rd_d;
      if (push_i != pop_i) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  assign head_o  = mem_q[rd_q];
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    push_i |-> !full_o); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R10
endmodule

// File: rtl/card_lane_engine.sv
module card_lane_engine
  import card_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              run_i,
  input  logic              dir_rd_i,
  input  logic              cnt_zero_i,
  input  logic              cnt_last_i,
  input  logic              hold_i,
  input  logic              fifo_full_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_head_i,
  input  logic              host_push_i,
  input  logic              host_pop_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i,
  output logic              byte_take_o,
  output logic              push_req_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              pop_req_o
);
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [DATA_W-1:0] pack_q, pack_d;
  logic rx_take, tx_take, word_end;

  assign rx_ready_o  = run_i && dir_rd_i && !cnt_zero_i && !hold_i && !fifo_full_i && !host_push_i;
  assign tx_valid_o  = run_i && !dir_rd_i && !cnt_zero_i && !fifo_empty_i && !host_pop_i;
  assign tx_data_o   = fifo_head_i[{lane_q, 3'b000} +: 8];
  assign rx_take     = rx_ready_o && rx_valid_i;
  assign tx_take     = tx_valid_o && tx_ready_i;
  assign byte_take_o = rx_take || tx_take;
  assign word_end    = byte_take_o && ((lane_q == LANE_W'(BPW - 1)) || cnt_last_i);
  assign push_data_o = pack_q | (DATA_W'(rx_data_i) << {lane_q, 3'b000});
  assign push_req_o  = rx_take && word_end;
  assign pop_req_o   = tx_take && word_end;

  always_comb begin
    lane_d = lane_q;
    pack_d = pack_q;
    if (start_i) begin
      lane_d = '0;
      pack_d = '0;
    end else if (byte_take_o) begin
      lane_d = word_end ? '0 : lane_q + LANE_W'(1);
      if (rx_take) pack_d = word_end ? '0 : push_data_o;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= '0;
      pack_q <= '0;
    end else if (start_i || byte_take_o) begin
      lane_q <= lane_d;
      pack_q <= pack_d;
    end
  end

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_ni)
    !(rx_take && tx_take)); // R5
  AST_WORD_RESTART: assert property (@(posedge clk) disable iff (!rst_ni)
    (push_req_o || pop_req_o) && !start_i |=> lane_q == '0); // R4
endmodule

// File: rtl/card_irq_gen.sv
module card_irq_gen #(
  parameter int N = 2,
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [W-1:0]     status_i,
  input  logic [N-1:0][W-1:0] mask_i,
  output logic [N-1:0]     irq_o
);
  logic [N-1:0] irq_d, irq_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign irq_d[i] = |(status_i & mask_i[i]);

    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_ni)
      (|(status_i & mask_i[i])) |=> irq_o[i]); // R11
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine
  import card_fifo_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              card_rx_valid_i,
  input  logic [7:0]        card_rx_data_i,
  output logic              card_rx_ready_o,
  output logic              card_tx_valid_o,
  output logic [7:0]        card_tx_data_o,
  input  logic              card_tx_ready_i,
  output logic [NIRQ-1:0]   irq_o
);
  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [CNT_W-1:0]  len_q, len_d, cnt_q, cnt_d;
  logic [7:0]        ctrl_q, ctrl_d;
  logic [DATA_W-1:0] status_q, status_d;
  logic [NIRQ-1:0][DATA_W-1:0] mask_q, mask_d;
  logic              hold_q, hold_d;

  logic host_wr, host_rd, in_win, ctrl_we, len_we, sclr_we, start, poll;
  logic cnt_zero, cnt_last, en, host_push, host_pop;
  logic fifo_full, fifo_empty, fifo_push, fifo_pop;
  logic [DATA_W-1:0] fifo_head, fifo_din, lane_push_data;
  logic lane_push, lane_pop, byte_take;
  logic [NIRQ-1:0] mask_we;
  logic [CNT_W:0] words_left;

  assign host_wr   = bus_sel_i && bus_wr_i;
  assign host_rd   = bus_sel_i && !bus_wr_i;
  assign in_win    = (bus_addr_i >= WIN_BASE) && (bus_addr_i <= WIN_TOP);
  assign ctrl_we   = host_wr && (bus_addr_i == OFS_CTRL);
  assign len_we    = host_wr && (bus_addr_i == OFS_LEN);
  assign sclr_we   = host_wr && (bus_addr_i == OFS_SCLR);
  assign start     = ctrl_we && bus_wdata_i[CTRL_EN];
  assign poll      = host_rd && ((bus_addr_i == OFS_STAT) || (bus_addr_i == OFS_FCNT));
  assign cnt_zero  = (cnt_q == '0);
  assign cnt_last  = (cnt_q == CNT_W'(1));
  assign en        = ctrl_q[CTRL_EN];
  assign host_push = host_wr && in_win && !cnt_zero && !fifo_full;
  assign host_pop  = host_rd && in_win && !fifo_empty;
  assign fifo_push = host_push || lane_push;
  assign fifo_din  = host_push ? bus_wdata_i : lane_push_data;
  assign fifo_pop  = host_pop || lane_pop;
  assign words_left = ({1'b0, cnt_q} + (CNT_W+1)'(BPW - 1)) >> LANE_W;

  card_word_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk(clk), .rst_ni(rst_ni),
    .push_i(fifo_push), .din_i(fifo_din), .pop_i(fifo_pop),
    .head_o(fifo_head), .full_o(fifo_full), .empty_o(fifo_empty)
  );

  card_lane_engine u_lane (
    .clk(clk), .rst_ni(rst_ni),
    .start_i(start), .run_i(en), .dir_rd_i(ctrl_q[CTRL_RD]),
    .cnt_zero_i(cnt_zero), .cnt_last_i(cnt_last), .hold_i(hold_q),
    .fifo_full_i(fifo_full), .fifo_empty_i(fifo_empty), .fifo_head_i(fifo_head),
    .host_push_i(host_push), .host_pop_i(host_pop),
    .rx_valid_i(card_rx_valid_i), .rx_data_i(card_rx_data_i), .rx_ready_o(card_rx_ready_o),
    .tx_valid_o(card_tx_valid_o), .tx_data_o(card_tx_data_o), .tx_ready_i(card_tx_ready_i),
    .byte_take_o(byte_take), .push_req_o(lane_push), .push_data_o(lane_push_data),
    .pop_req_o(lane_pop)
  );

  card_irq_gen #(.N(NIRQ), .W(DATA_W)) u_irq (
    .clk(clk), .rst_ni(rst_ni), .status_i(status_q), .mask_i(mask_q), .irq_o(irq_o)
  );

  // next-state logic
  always_comb begin
    len_d    = len_we ? bus_wdata_i[CNT_W-1:0] : len_q;
    cnt_d    = cnt_q;
    if (start)          cnt_d = len_q;
    else if (byte_take) cnt_d = cnt_q - CNT_W'(1);
    ctrl_d   = ctrl_q;
    if (ctrl_we)                          ctrl_d = bus_wdata_i[7:0];
    else if (en && cnt_zero && fifo_empty) ctrl_d[CTRL_EN] = 1'b0;
    status_d = status_q;
    if (sclr_we)       status_d = status_q & ~bus_wdata_i;
    if (en && cnt_zero) status_d[STAT_END] = 1'b1;
    hold_d   = hold_q;
    if (host_pop)  hold_d = 1'b1;
    else if (poll) hold_d = 1'b0;
    for (int i = 0; i < NIRQ; i++) begin
      mask_we[i] = host_wr && (bus_addr_i == ADDR_W'(OFS_MASK0 + 4 * i));
      mask_d[i]  = mask_we[i] ? bus_wdata_i : mask_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q    <= '0;
      cnt_q    <= '0;
      ctrl_q   <= '0;
      status_q <= '0;
      mask_q   <= '0;
      hold_q   <= 1'b0;
    end else begin
      if (len_we)                  len_q    <= len_d;
      if (start || byte_take)      cnt_q    <= cnt_d;
      if (ctrl_we || en)           ctrl_q   <= ctrl_d;
      if (sclr_we || en)           status_q <= status_d;
      if (host_pop || poll)        hold_q   <= hold_d;
      if (|mask_we)                mask_q   <= mask_d;
    end
  end

  // register read
  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      OFS_LEN:  bus_rdata_o = DATA_W'(len_q);
      OFS_CTRL: bus_rdata_o = DATA_W'(ctrl_q);
      OFS_CNT:  bus_rdata_o = DATA_W'(cnt_q);
      OFS_STAT: bus_rdata_o = status_q;
      OFS_FCNT: bus_rdata_o = DATA_W'(words_left);
      default: begin
        for (int i = 0; i < NIRQ; i++)
          if (bus_addr_i == ADDR_W'(OFS_MASK0 + 4 * i)) bus_rdata_o = mask_q[i];
        if (in_win && !fifo_empty) bus_rdata_o = fifo_head;
      end
    endcase
  end

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_we |=> ctrl_q == $past(bus_wdata_i[7:0])); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    byte_take && !start |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R4
  AST_END_SET: assert property (@(posedge clk) disable iff (!rst_ni)
    en && cnt_zero |=> status_q[STAT_END]); // R6
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    en && cnt_zero && fifo_empty && !ctrl_we |=> !ctrl_q[CTRL_EN]); // R7
  AST_HOLD_BLOCKS_RX: assert property (@(posedge clk) disable iff (!rst_ni)
    hold_q |-> !card_rx_ready_o); // R8
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_ni)
    poll |=> !hold_q); // R9
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    host_rd && in_win && fifo_empty |-> bus_rdata_o == '0); // R10
  AST_EMPTY_READ_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    host_rd && in_win && fifo_empty && !hold_q |=> !hold_q); // R10
endmodule

// File: tb/card_fifo_engine_bench.sv
module card_fifo_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam logic [11:0] A_LEN = 12'h028, A_CTRL = 12'h02C, A_CNT = 12'h030,
    A_STAT = 12'h034, A_SCLR = 12'h038, A_MA = 12'h03C, A_MB = 12'h040, A_FCNT = 12'h048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rx_valid = 0, rx_ready, tx_valid, tx_ready = 0;
  logic [7:0] rx_data = '0, tx_data;
  logic [1:0] irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0]  bq [0:255];
  logic [31:0] wq [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  card_fifo_engine u_card_fifo_engine (
    .clk(clk), .rst_n(rst_n),
    .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .card_rx_valid_i(rx_valid), .card_rx_data_i(rx_data), .card_rx_ready_o(rx_ready),
    .card_tx_valid_o(tx_valid), .card_tx_data_o(tx_data), .card_tx_ready_i(tx_ready),
    .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  function automatic logic [11:0] win_addr();
    return 12'h080 + 12'(($urandom % 16) * 4);
  endfunction

  // expected word k of a card-read transfer of n bytes, LSB first, zero fill
  function automatic logic [31:0] exp_word(input int k, input int n);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4 * k + j < n) w[8*j +: 8] = bq[4 * k + j];
    return w;
  endfunction

  task automatic feed(input int first, input int count, input int max_cyc, output int taken);
    int c = 0;
    taken = 0;
    while (taken < count && c < max_cyc) begin
      rx_valid = 1; rx_data = bq[first + taken];
      if (rx_ready) taken++;
      @(posedge clk); @(negedge clk);
      c++;
    end
    rx_valid = 0;
  endtask

  task automatic drain_check(input int n, input string tag);
    int k = 0, c = 0;
    tx_ready = 1;
    while (k < n && c < 1000) begin
      if (tx_valid) begin
        chk(tx_data == wq[k/4][8*(k%4) +: 8], tag, 32'(tx_data), 32'(wq[k/4][8*(k%4) +: 8]));
        k++;
      end
      @(posedge clk); @(negedge clk);
      c++;
    end
    tx_ready = 0;
    chk(k == n, {tag, " byte count"}, k, n);
  endtask

  task automatic finish_xfer(input string tag);
    logic [31:0] d;
    idle(2);
    bus_read(A_CTRL, d);
    chk(d[0] == 1'b0, "R7 enable cleared when done", d, {d[31:1], 1'b0});
    bus_read(A_STAT, d);
    chk(d[0] == 1'b1, {"R6 block end set ", tag}, d, 32'h1);
    bus_write(A_SCLR, 32'h1);
    bus_read(A_STAT, d);
    chk(d == 32'h0, "R6 status cleared by W1C", d, 32'h0);
  endtask

  task automatic rd_run(input int n);
    logic [31:0] d;
    int taken;
    for (int i = 0; i < n; i++) bq[i] = 8'($urandom);
    bus_write(A_LEN, 32'(n));
    bus_write(A_CTRL, 32'h3);
    bus_read(A_FCNT, d);
    chk(d == 32'((n + 3) >> 2), "R3 word count before feed", d, 32'((n + 3) >> 2));
    feed(0, n, 4 * n + 20, taken);
    chk(taken == n, "R4 bytes accepted", taken, n);
    idle(1);
    bus_read(A_FCNT, d);
    chk(d == 0, "R3 word count after feed", d, 0);
    for (int k = 0; k < (n + 3) / 4; k++) begin
      bus_read(win_addr(), d);
      chk(d == exp_word(k, n), "R4 packed word", d, exp_word(k, n));
    end
    finish_xfer("read mode");
  endtask

  task automatic wr_run(input int n);
    logic [31:0] d;
    bus_write(A_LEN, 32'(n));
    bus_write(A_CTRL, 32'h1);
    for (int k = 0; k < (n + 3) / 4; k++) begin
      wq[k] = $urandom;
      bus_write(win_addr(), wq[k]);
    end
    bus_read(A_CNT, d);
    chk(d == 32'(n), "R2 counter loaded", d, n);
    drain_check(n, "R5 unpacked byte");
    finish_xfer("write mode");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int taken;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1;
    idle(4);

    // R1 reset state
    bus_read(A_CTRL, d); chk(d == 0, "R1 control reset", d, 0);
    bus_read(A_CNT,  d); chk(d == 0, "R1 counter reset", d, 0);
    bus_read(A_STAT, d); chk(d == 0, "R1 status reset", d, 0);
    bus_read(A_MA,   d); chk(d == 0, "R1 mask A reset", d, 0);
    bus_read(A_MB,   d); chk(d == 0, "R1 mask B reset", d, 0);
    chk(irq == 2'b00, "R1 irq low", irq, 0);

    // R2 only low byte kept, no start without enable
    bus_write(A_LEN, 32'd20);
    bus_write(A_CTRL, 32'hABCDEF5C);
    bus_read(A_CTRL, d); chk(d == 32'h5C, "R2 low byte kept", d, 32'h5C);
    bus_read(A_CNT, d);  chk(d == 0, "R2 no load without enable", d, 0);
    bus_write(A_CTRL, 32'h0);

    // masks for the interrupt test
    bus_write(A_MA, 32'h1);
    bus_write(A_MB, 32'h2);

    // R10 empty read returns zero and sets no hold
    for (int i = 0; i < 8; i++) bq[i] = 8'(8'hA0 + i);
    bus_write(A_LEN, 32'd8);
    bus_write(A_CTRL, 32'h3);
    bus_read(win_addr(), d);
    chk(d == 0, "R10 empty FIFO read is zero", d, 0);
    chk(rx_ready == 1'b1, "R10 empty read sets no hold", rx_ready, 1);

    // R8 / R9 hold after pop
    feed(0, 4, 20, taken);
    idle(1);
    bus_read(win_addr(), d);
    chk(d == 32'hA3A2A1A0, "R4 first word LSB first", d, 32'hA3A2A1A0);
    chk(rx_ready == 1'b0, "R8 hold blocks refill", rx_ready, 0);
    feed(4, 4, 3, taken);
    bus_read(A_CNT, d);
    chk(d == 32'd4, "R8 counter frozen under hold", d, 4);
    bus_read(A_STAT, d);
    chk(rx_ready == 1'b1, "R9 status poll releases hold", rx_ready, 1);
    feed(4, 4, 20, taken);
    idle(1);
    bus_read(win_addr(), d);
    chk(d == 32'hA7A6A5A4, "R4 second word", d, 32'hA7A6A5A4);
    idle(2);
    // R11 irq one cycle after status change
    chk(irq == 2'b01, "R11 irq A raised by masked status", irq, 2'b01);
    bus_write(A_SCLR, 32'h1);
    chk(irq[0] == 1'b1, "R11 irq lags status by a cycle", irq, 2'b01);
    idle(1);
    chk(irq == 2'b00, "R11 irq follows cleared status", irq, 0);
    bus_read(A_FCNT, d);
    chk(d == 0, "R9 word count poll", d, 0);

    // R4 stop at sixteen words
    for (int i = 0; i < 68; i++) bq[i] = 8'($urandom);
    bus_write(A_LEN, 32'd68);
    bus_write(A_CTRL, 32'h3);
    feed(0, 68, 90, taken);
    chk(taken == 64, "R4 FIFO full stops refill", taken, 64);
    bus_read(A_FCNT, d);
    chk(d == 32'd1, "R3 word count rounds up", d, 1);
    bus_read(win_addr(), d);
    chk(d == exp_word(0, 68), "R4 word after full", d, exp_word(0, 68));
    bus_read(A_FCNT, d);
    feed(64, 4, 20, taken);
    chk(taken == 4, "R4 refill after space", taken, 4);
    for (int k = 1; k < 17; k++) begin
      bus_read(win_addr(), d);
      chk(d == exp_word(k, 68), "R4 full transfer word", d, exp_word(k, 68));
    end
    finish_xfer("full transfer");

    // R10 write with counter zero dropped
    bus_write(win_addr(), 32'hDEADBEEF);
    bus_write(A_LEN, 32'd4);
    bus_write(A_CTRL, 32'h1);
    idle(1);
    chk(tx_valid == 1'b0, "R10 write with zero count dropped", tx_valid, 0);
    wq[0] = 32'h44332211;
    bus_write(win_addr(), wq[0]);
    drain_check(4, "R5 directed byte order");
    finish_xfer("directed write");

    // boundary and random transfers
    rd_run(1);
    rd_run(64);
    wr_run(1);
    wr_run(61);
    for (int it = 0; it < 6; it++) begin
      rd_run(1 + int'($urandom % 64));
      wr_run(1 + int'($urandom % 64));
    end

    bus_read(A_STAT, d);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule